// File: doc/BRIEF.md
# I/O-Mapped Test Environment Controller

This peripheral sits on the I/O write/read strobe bus of an 8-bit processor and lets the program under test steer its own simulation environment. Writes into the environment window set sticky end-of-test flags (pass, fail or timeout) and a waveform-dump request level. They also append message characters to a line buffer, program a watchdog and load a countdown for a delayed active-low interrupt. Bytes outside the window are left for other devices.

Completed message lines leave the block as one parallel bundle. The bundle holds the characters, the length and a one-cycle valid pulse. There is no back-pressure on this output: no ready input exists, and a receiver that wants the line must capture it in the pulse cycle. The buffer starts the next line at once. The processor-side strobes are single-cycle and are always accepted.

Top module: `simenv_ctl`

## Requirements
- R1: Only addresses 0x80 to 0x9F (address bits 7:5 equal to 100) are decoded. A write elsewhere changes no flag, buffer, counter or interrupt. A read elsewhere returns 0x00, as does a read of any window port other than 0x82, 0x83 and 0x84.
- R2: Writing 0x01 to port 0x80 sets `test_pass` and writing 0x02 sets `test_fail`, one cycle after the write. Both flags, like `test_timeout`, stay set until reset. While any of the three is set, further 0x01 and 0x02 writes are ignored.
- R3: Writing 0x03 to port 0x80 sets `dump_on` and writing 0x04 clears it. It is 0 after reset. Any other code at 0x80 changes nothing.
- R4: Each byte other than 0x0A written to port 0x81 is stored at the next free position of an 80-character buffer. Character i appears on `line_data[8i+7:8i]`. Bytes arriving when 80 are already held are dropped.
- R5: A write of 0x0A to port 0x81 raises `line_valid` for exactly the next cycle, with `line_len` giving the number of stored characters (0 to 80). The newline is not stored and the next line starts at position 0.
- R6: The watchdog is enabled after reset and counts one per clock, saturating at 0xFFFF. With the count cleared by a write at edge E and limit L, `test_timeout` is 0 after edge E+L and 1 after edge E+L+1. It is raised only while enabled, and not if pass or fail is already set.
- R7: A write to port 0x82 sets the enable from bit 0 and, if bit 1 is 1, clears the count in that same write. While disabled, the count holds and no timeout is raised. Reading 0x82 returns the enable in bit 0.
- R8: Port 0x83 holds the low byte and port 0x84 the high byte of the 16-bit limit, which is 0xFFFF after reset. Both ports read back their byte.
- R9: Writing N (1 to 255) to port 0x90 at edge E keeps `int_n` high through edge E+N-1 and drives it low from edge E+N. It stays low until port 0x90 is written again, and a nonzero rewrite deasserts it and restarts the countdown.
- R10: Writing 0x00 to port 0x90 drives `int_n` high on the next cycle and cancels a countdown in flight. `int_n` is high after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_rd | input | 1 | I/O read strobe, data returned in the same cycle |
| io_addr | input | 8 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, 0x00 when not selected |
| test_pass | output | 1 | Sticky pass flag |
| test_fail | output | 1 | Sticky fail flag |
| test_timeout | output | 1 | Sticky watchdog expiry flag |
| dump_on | output | 1 | Waveform dump request level |
| line_valid | output | 1 | One-cycle pulse, a complete message line is presented |
| line_len | output | 7 | Characters in the presented line |
| line_data | output | 640 | Line characters, position i in bits 8i+7:8i |
| int_n | output | 1 | Active-low delayed interrupt |

## Verification
Two functions can meet in one cycle: a watchdog expiry and an end-of-test command. The bench lets a short limit expire and then writes the pass code, so the sticky timeout must block the later pass. It also separates a pass from a fail by placing the end command a cycle after the other flag. The second meeting point is a newline that arrives when the buffer is already full of dropped bytes. This is provoked by random line lengths above 80, with a bench model predicting `line_len` of exactly 80 and the stored prefix.

// File: rtl/simenv_pkg.sv
package simenv_pkg;
  localparam logic [2:0] WIN_TAG   = 3'b100;
  localparam logic [7:0] A_SIMCTL  = 8'h80;
  localparam logic [7:0] A_MSG     = 8'h81;
  localparam logic [7:0] A_WDCTL   = 8'h82;
  localparam logic [7:0] A_LIM_LO  = 8'h83;
  localparam logic [7:0] A_LIM_HI  = 8'h84;
  localparam logic [7:0] A_IRQ     = 8'h90;

  localparam logic [7:0] CODE_PASS     = 8'h01;
  localparam logic [7:0] CODE_FAIL     = 8'h02;
  localparam logic [7:0] CODE_DUMP_ON  = 8'h03;
  localparam logic [7:0] CODE_DUMP_OFF = 8'h04;
  localparam logic [7:0] CHAR_NL       = 8'h0A;

  typedef struct packed {
    logic simctl;
    logic msg;
    logic wdctl;
    logic lim_lo;
    logic lim_hi;
    logic irq;
  } wr_sel_t;
endpackage

// File: rtl/simenv_decode.sv
module simenv_decode
  import simenv_pkg::*;
(
  input  logic       io_wr,
  input  logic [7:0] io_addr,
  output logic       in_win,
  output wr_sel_t    sel
);
  always_comb begin
    in_win = (io_addr[7:5] == WIN_TAG);
    sel    = '0;
    if (io_wr && in_win) begin
      sel.simctl = (io_addr == A_SIMCTL);
      sel.msg    = (io_addr == A_MSG);
      sel.wdctl  = (io_addr == A_WDCTL);
      sel.lim_lo = (io_addr == A_LIM_LO);
      sel.lim_hi = (io_addr == A_LIM_HI);
      sel.irq    = (io_addr == A_IRQ);
    end
  end
endmodule

// File: rtl/simenv_linebuf.sv
module simenv_linebuf
  import simenv_pkg::*;
#(
  parameter int LINE_MAX = 80,
  localparam int LEN_W   = $clog2(LINE_MAX + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  push,
  input  logic [7:0]            din,
  output logic                  line_valid,
  output logic [LEN_W-1:0]      line_len,
  output logic [LINE_MAX*8-1:0] line_data
);
  logic [LEN_W-1:0] fill_q;
  logic [7:0]       mem_q [LINE_MAX];
  logic             is_nl;
  logic             room;

  assign is_nl = (din == CHAR_NL);
  assign room  = (fill_q < LEN_W'(LINE_MAX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_q     <= '0;
      line_valid <= 1'b0;
      line_len   <= '0;
    end else begin
      line_valid <= 1'b0;
      if (push) begin
        if (is_nl) begin
          line_valid <= 1'b1;
          line_len   <= fill_q;
          fill_q     <= '0;
        end else if (room) begin
          fill_q <= fill_q + 1'b1;
        end
      end
    end
  end

  for (genvar i = 0; i < LINE_MAX; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        mem_q[i] <= '0;
      else if (push && !is_nl && fill_q == LEN_W'(i))
        mem_q[i] <= din;
    end
    assign line_data[8*i +: 8] = mem_q[i];
  end
endmodule

// File: rtl/simenv_watchdog.sv
module simenv_watchdog #(
  parameter int          CNT_W     = 16,
  parameter logic [15:0] LIMIT_RST = 16'hFFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic             lo_we,
  input  logic             hi_we,
  input  logic [7:0]       wdata,
  output logic             enabled,
  output logic [CNT_W-1:0] limit,
  output logic             expired
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             clr;

  assign clr = ctl_we && wdata[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enabled <= 1'b1;
      cnt_q   <= '0;
      limit   <= CNT_W'(LIMIT_RST);
    end else begin
      if (ctl_we) enabled <= wdata[0];
      if (clr)
        cnt_q <= '0;
      else if (enabled && cnt_q != CNT_TOP)
        cnt_q <= cnt_q + 1'b1;
      if (lo_we) limit[7:0]       <= wdata;
      if (hi_we) limit[CNT_W-1:8] <= wdata[CNT_W-9:0];
    end
  end

  assign expired = enabled && !clr && (cnt_q >= limit);
endmodule

// File: rtl/simenv_irqdelay.sv
module simenv_irqdelay #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] count,
  output logic             int_n
);
  logic [CNT_W-1:0] left_q;
  logic             armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q  <= '0;
      armed_q <= 1'b0;
      int_n   <= 1'b1;
    end else if (load) begin
      int_n   <= 1'b1;
      left_q  <= count;
      armed_q <= (count != '0);
    end else if (armed_q) begin
      if (left_q == CNT_W'(1)) begin
        int_n   <= 1'b0;
        armed_q <= 1'b0;
      end else begin
        left_q <= left_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/simenv_ctl.sv
module simenv_ctl
  import simenv_pkg::*;
#(
  parameter int          LINE_MAX      = 80,
  parameter int          TMO_W         = 16,
  parameter logic [15:0] TMO_LIMIT_RST = 16'hFFFF,
  parameter int          IRQ_W         = 8,
  localparam int         LEN_W         = $clog2(LINE_MAX + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  io_wr,
  input  logic                  io_rd,
  input  logic [7:0]            io_addr,
  input  logic [7:0]            io_wdata,
  output logic [7:0]            io_rdata,
  output logic                  test_pass,
  output logic                  test_fail,
  output logic                  test_timeout,
  output logic                  dump_on,
  output logic                  line_valid,
  output logic [LEN_W-1:0]      line_len,
  output logic [LINE_MAX*8-1:0] line_data,
  output logic                  int_n
);
  logic             in_win;
  wr_sel_t          sel;
  logic             wd_en;
  logic [TMO_W-1:0] wd_limit;
  logic             wd_expired;
  logic             ended;

  simenv_decode u_dec (
    .io_wr  (io_wr),
    .io_addr(io_addr),
    .in_win (in_win),
    .sel    (sel)
  );

  simenv_linebuf #(.LINE_MAX(LINE_MAX)) u_line (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (sel.msg),
    .din       (io_wdata),
    .line_valid(line_valid),
    .line_len  (line_len),
    .line_data (line_data)
  );

  simenv_watchdog #(.CNT_W(TMO_W), .LIMIT_RST(TMO_LIMIT_RST)) u_wd (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctl_we (sel.wdctl),
    .lo_we  (sel.lim_lo),
    .hi_we  (sel.lim_hi),
    .wdata  (io_wdata),
    .enabled(wd_en),
    .limit  (wd_limit),
    .expired(wd_expired)
  );

  simenv_irqdelay #(.CNT_W(IRQ_W)) u_irq (
    .clk  (clk),
    .rst_n(rst_n),
    .load (sel.irq),
    .count(io_wdata[IRQ_W-1:0]),
    .int_n(int_n)
  );

  assign ended = test_pass || test_fail || test_timeout;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      test_pass    <= 1'b0;
      test_fail    <= 1'b0;
      test_timeout <= 1'b0;
      dump_on      <= 1'b0;
    end else begin
      if (!ended) begin
        if (wd_expired)
          test_timeout <= 1'b1;
        else if (sel.simctl && io_wdata == CODE_PASS)
          test_pass <= 1'b1;
        else if (sel.simctl && io_wdata == CODE_FAIL)
          test_fail <= 1'b1;
      end
      if (sel.simctl && io_wdata == CODE_DUMP_ON)  dump_on <= 1'b1;
      if (sel.simctl && io_wdata == CODE_DUMP_OFF) dump_on <= 1'b0;
    end
  end

  always_comb begin
    io_rdata = 8'h00;
    if (io_rd && in_win) begin
      case (io_addr)
        A_WDCTL:  io_rdata = {7'b0, wd_en};
        A_LIM_LO: io_rdata = wd_limit[7:0];
        A_LIM_HI: io_rdata = wd_limit[TMO_W-1:8];
        default:  io_rdata = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/simenv_chk.sv
module simenv_chk #(
  parameter int LINE_MAX = 80,
  localparam int LEN_W   = $clog2(LINE_MAX + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             io_wr,
  input logic             io_rd,
  input logic [7:0]       io_addr,
  input logic [7:0]       io_wdata,
  input logic [7:0]       io_rdata,
  input logic             test_pass,
  input logic             test_fail,
  input logic             test_timeout,
  input logic             dump_on,
  input logic             line_valid,
  input logic [LEN_W-1:0] line_len,
  input logic             int_n
);
  // R1
  outside_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr[7:5] != 3'b100) |-> io_rdata == 8'h00);

  // R2
  end_flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({test_pass, test_fail, test_timeout}) <= 1);

  // R2
  pass_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_pass |=> test_pass);

  // R2
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_fail |=> test_fail);

  // R6
  timeout_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_timeout |=> test_timeout);

  // R3
  dump_on_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == 8'h80 && io_wdata == 8'h03) |=> dump_on);

  // R5
  line_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |-> $past(io_wr && io_addr == 8'h81 && io_wdata == 8'h0A));

  // R4
  line_len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |-> line_len <= LEN_W'(LINE_MAX));

  // R10
  irq_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == 8'h90 && io_wdata == 8'h00) |=> int_n);
endmodule

bind simenv_ctl simenv_chk #(.LINE_MAX(LINE_MAX)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .io_wr       (io_wr),
  .io_rd       (io_rd),
  .io_addr     (io_addr),
  .io_wdata    (io_wdata),
  .io_rdata    (io_rdata),
  .test_pass   (test_pass),
  .test_fail   (test_fail),
  .test_timeout(test_timeout),
  .dump_on     (dump_on),
  .line_valid  (line_valid),
  .line_len    (line_len),
  .int_n       (int_n)
);

// File: tb/sim_simenv_ctl.sv
`timescale 1ns/1ps
module sim_simenv_ctl;
  localparam int LINE_MAX = 80;
  localparam int LEN_W    = $clog2(LINE_MAX + 1);

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  io_wr = 1'b0;
  logic                  io_rd = 1'b0;
  logic [7:0]            io_addr = 8'h00;
  logic [7:0]            io_wdata = 8'h00;
  logic [7:0]            io_rdata;
  logic                  test_pass, test_fail, test_timeout, dump_on;
  logic                  line_valid;
  logic [LEN_W-1:0]      line_len;
  logic [LINE_MAX*8-1:0] line_data;
  logic                  int_n;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  finished = 1'b0;
  logic [7:0] model [100];

  simenv_ctl #(.LINE_MAX(LINE_MAX)) u0 (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .test_pass(test_pass), .test_fail(test_fail), .test_timeout(test_timeout),
    .dump_on(dump_on), .line_valid(line_valid), .line_len(line_len),
    .line_data(line_data), .int_n(int_n)
  );

  always #10 clk = ~clk;

  function automatic int exp_len(int n);
    return (n > LINE_MAX) ? LINE_MAX : n;
  endfunction

  function automatic logic [7:0] rand_char();
    return 8'(32'h20 + ($urandom % 95));
  endfunction

  function automatic logic [7:0] rand_outside_addr();
    logic [7:0] a;
    a = 8'($urandom);
    if (a[7:5] == 3'b100) a[7:5] = 3'b011;
    return a;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    io_rd = 1'b1; io_addr = a;
    #2 d = io_rdata;
    io_rd = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send_line(int n, logic [7:0] noise_addr);
    for (int i = 0; i < n; i++) begin
      model[i] = rand_char();
      wr(8'h81, model[i]);
    end
    wr(noise_addr, 8'h0A);
    chk("R1 outside newline ignored", {31'b0, line_valid}, 32'd0);
    wr(8'h81, 8'h0A);
    chk("R5 line_valid pulse", {31'b0, line_valid}, 32'd1);
    chk("R4 R5 line_len", 32'(line_len), 32'(exp_len(n)));
    for (int i = 0; i < exp_len(n); i++)
      chk("R4 stored char", 32'(line_data[8*i +: 8]), 32'(model[i]));
    @(negedge clk);
    chk("R5 pulse one cycle", {31'b0, line_valid}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    void'($urandom(32'd4242));
    do_reset();
    @(negedge clk);
    // reset state
    chk("R2 pass reset", {31'b0, test_pass}, 0);
    chk("R2 fail reset", {31'b0, test_fail}, 0);
    chk("R3 dump reset", {31'b0, dump_on}, 0);
    chk("R10 int_n reset", {31'b0, int_n}, 1);
    rd(8'h82, r); chk("R7 enable after reset", 32'(r), 32'h01);
    rd(8'h83, r); chk("R8 limit lo reset", 32'(r), 32'hFF);
    rd(8'h84, r); chk("R8 limit hi reset", 32'(r), 32'hFF);
    rd(8'h80, r); chk("R1 unreadable port", 32'(r), 0);

    // message lines: directed and random lengths
    send_line(0, 8'h01);
    send_line(LINE_MAX, 8'h7F);
    send_line(LINE_MAX + 1, 8'hA0);
    for (int k = 0; k < 12; k++)
      send_line(int'($urandom % 101), rand_outside_addr());

    // random outside writes must touch nothing
    for (int k = 0; k < 40; k++)
      wr(rand_outside_addr(), 8'($urandom));
    chk("R1 outside pass", {31'b0, test_pass}, 0);
    chk("R1 outside dump", {31'b0, dump_on}, 0);
    chk("R1 outside int", {31'b0, int_n}, 1);
    rd(8'h83, r); chk("R1 limit untouched", 32'(r), 32'hFF);
    rd(8'h03, r); chk("R1 outside read", 32'(r), 0);

    // dump
    wr(8'h80, 8'h03); chk("R3 dump on", {31'b0, dump_on}, 1);
    wr(8'h80, 8'h07); chk("R3 unknown code", {31'b0, dump_on}, 1);
    wr(8'h80, 8'h04); chk("R3 dump off", {31'b0, dump_on}, 0);

    // interrupt countdown
    for (int k = 0; k < 4; k++) begin
      int n;
      n = (k == 0) ? 1 : 1 + int'($urandom % 20);
      wr(8'h90, 8'(n));
      repeat (n - 1) @(negedge clk);
      chk("R9 int_n before expiry", {31'b0, int_n}, 1);
      @(negedge clk);
      chk("R9 int_n at expiry", {31'b0, int_n}, 0);
      repeat (5) @(negedge clk);
      chk("R9 int_n held low", {31'b0, int_n}, 0);
    end
    wr(8'h90, 8'd3);
    chk("R9 rewrite deasserts", {31'b0, int_n}, 1);
    wr(8'h90, 8'd0);
    chk("R10 zero deasserts", {31'b0, int_n}, 1);
    repeat (10) @(negedge clk);
    chk("R10 countdown cancelled", {31'b0, int_n}, 1);

    // pass then fail ignored
    wr(8'h80, 8'h01); chk("R2 pass set", {31'b0, test_pass}, 1);
    wr(8'h80, 8'h02); chk("R2 fail ignored after pass", {31'b0, test_fail}, 0);
    chk("R2 pass kept", {31'b0, test_pass}, 1);

    // session 2: fail then pass ignored
    do_reset();
    wr(8'h80, 8'h02); chk("R2 fail set", {31'b0, test_fail}, 1);
    wr(8'h80, 8'h01); chk("R2 pass ignored after fail", {31'b0, test_pass}, 0);

    // session 3: watchdog
    do_reset();
    wr(8'h82, 8'h02);
    rd(8'h82, r); chk("R7 enable cleared", 32'(r), 0);
    wr(8'h83, 8'h05);
    wr(8'h84, 8'h00);
    rd(8'h83, r); chk("R8 limit lo", 32'(r), 32'h05);
    rd(8'h84, r); chk("R8 limit hi", 32'(r), 0);
    repeat (30) @(negedge clk);
    chk("R7 disabled no timeout", {31'b0, test_timeout}, 0);
    begin
      int lim;
      lim = 8 + int'($urandom % 40);
      wr(8'h83, 8'(lim));
      wr(8'h82, 8'h03);
      repeat (lim) @(negedge clk);
      chk("R6 no timeout at limit edge", {31'b0, test_timeout}, 0);
      @(negedge clk);
      chk("R6 timeout one edge later", {31'b0, test_timeout}, 1);
    end
    wr(8'h80, 8'h01);
    chk("R2 pass ignored after timeout", {31'b0, test_pass}, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule